// File: doc/BRIEF.md
# Fractional-Divider PWM Base Timer

This block is the shared time base for a group of LED-dimming PWM channels. Two tick-enable inputs arrive from elsewhere in the chip: a slow-clock tick and a reference tick. A select bit in a 32-bit configuration word picks one of them. The chosen tick feeds a phase-accumulator divider whose ratio carries eight fractional bits, so the divided tick rate can be set in steps of 1/256 of the source rate. Every divided tick advances a counter whose range is a power of two given by an exponent field. The compare channels read the counter value and use the one-cycle wrap pulse as their period boundary.

The configuration word is written through a simple strobe and data pair. The divider and exponent fields are not used directly: they are copied into shadow registers only when the update-request bit is set, and that bit then clears itself. A small controller with three states, ST_HOLD, ST_RUN and ST_PAUSE, follows the clear and freeze bits of the word. The transitions are: to ST_HOLD whenever the clear bit is set (from any state); ST_HOLD to ST_RUN or ST_PAUSE once the clear bit drops (ST_PAUSE if the freeze bit is set); ST_RUN to ST_PAUSE when the freeze bit rises; ST_PAUSE to ST_RUN when it falls. Each state otherwise stays where it is. The controller state is registered from the configuration register, so a clear or freeze bit affects the counter from the second clock edge after the write.

Top module: `pwm_timebase`

## Requirements
- R1: The divided tick rate is the selected source rate times 256/D, where D is the 18-bit divider field (bits 22..5, low 8 bits fractional). The divider holds a phase accumulator that gains 256 per selected source tick and gives one divided tick, keeping the remainder, each time it reaches D. A D below 256 acts as 256, so no source tick yields more than one divided tick.
- R2: With an effective exponent E, the counter steps 0, 1, ..., 2^E-1 and then returns to 0 on divided ticks. E is the 5-bit limit field (bits 4..0), capped at the counter width CNT_W (20 by default).
- R3: Bit 26 requests an update. On the clock edge after it is seen in the configuration register, the divider and exponent shadows load from the register, and the bit clears unless a new write lands on that edge. Writes of the divider and limit fields without bit 26 have no effect on counting.
- R4: While bit 24 (clear) is set, the counter and the divider phase are forced to 0 from the second edge after the write, and no wrap pulse appears.
- R5: While bit 23 (freeze) is set and bit 24 is clear, the counter and divider phase keep their values from the second edge after the write. After the bit drops, counting resumes from the same phase, so no count is lost or added.
- R6: The wrap output is high for exactly the cycle in which the counter shows 0 after leaving its top value, and low otherwise.
- R7: Bit 25 selects the counting source: 1 uses slow_tick and 0 uses ref_tick. The unselected input has no effect. The selection acts on the first edge after the write.
- R8: After reset the configuration register, shadows and divider phase are all zero, the counter reads 0 and wrap is low.
- R9: The configuration word uses these positions: update at 26, source select at 25, clear at 24, freeze at 23, divider at 22..5 and limit at 4..0. The other bits are stored but unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Slow-clock tick enable, one cycle per tick |
| ref_tick | input | 1 | Reference tick enable, one cycle per tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cnt | output | CNT_W | Current counter value |
| wrap | output | 1 | One-cycle pulse when the counter returns to 0 from its top value |

## Verification
The hardest case to reach is the exponent cap. An exponent above the counter width only shows a difference once the counter has run through its full range, which at the default width takes about a million divided ticks. The bench therefore builds the timer with a 10-bit counter, writes an exponent of 25, and gives a reference tick every cycle until the counter has passed its 1023 top and wrapped. A second awkward case is the freeze in the middle of a fractional division. Freeze is applied while the accumulator holds a non-zero remainder, and source ticks keep arriving the whole time. The cycle-exact scoreboard then shows whether the first divided tick after resuming comes on schedule.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } tmr_state_e;

    // Configuration word layout (R9)
    localparam int BIT_UPD  = 26;
    localparam int BIT_SEL  = 25;
    localparam int BIT_CLR  = 24;
    localparam int BIT_HALT = 23;
    localparam int DIV_LSB  = 5;
    localparam int DIV_W    = 18;
    localparam int LIM_W    = 5;
    localparam int FRAC_W   = 8;
    localparam int CFG_W    = 32;

endpackage

// File: rtl/pwm_timebase_cfg.sv
module pwm_timebase_cfg
    import pwm_timebase_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CFG_W-1:0]    wr_data,
    output logic [CFG_W-1:0]    cfg_q,
    output logic [DIV_W-1:0]    div_sh,
    output logic [LIM_W-1:0]    lim_sh
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            div_sh <= '0;
            lim_sh <= '0;
        end else begin
            if (cfg_q[BIT_UPD]) begin
                div_sh <= cfg_q[DIV_LSB +: DIV_W];
                lim_sh <= cfg_q[LIM_W-1:0];
            end
            if (wr_en) begin
                cfg_q <= wr_data;
            end else if (cfg_q[BIT_UPD]) begin
                cfg_q[BIT_UPD] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pwm_timebase_frac_div.sv
module pwm_timebase_frac_div #(
    parameter int DIV_W  = 18,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [DIV_W-1:0]  div_set,
    output logic              tick
);

    localparam int ACC_W = DIV_W + 1;
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] div_eff;
    logic [ACC_W-1:0] sum;

    assign div_eff = ({1'b0, div_set} < ONE) ? ONE : {1'b0, div_set};
    assign sum     = acc_q + ONE;
    assign tick    = advance && (sum >= div_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (advance) begin
            acc_q <= tick ? (sum - div_eff) : sum;
        end
    end

endmodule

// File: rtl/pwm_timebase_range_cnt.sv
module pwm_timebase_range_cnt #(
    parameter int CNT_W = 20,
    parameter int LIM_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [LIM_W-1:0]  lim,
    output logic [CNT_W-1:0]  cnt,
    output logic              wrap
);

    logic [LIM_W-1:0] exp_eff;
    logic [CNT_W-1:0] top_val;

    assign exp_eff = (32'(lim) > CNT_W) ? LIM_W'(CNT_W) : lim;

    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign top_val[i] = (32'(exp_eff) > i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            wrap <= 1'b0;
        end else if (clear) begin
            cnt  <= '0;
            wrap <= 1'b0;
        end else begin
            wrap <= 1'b0;
            if (step) begin
                if (cnt == top_val) begin
                    cnt  <= '0;
                    wrap <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              ref_tick,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic              wrap
);

    logic [CFG_W-1:0] cfg_q;
    logic [DIV_W-1:0] div_sh;
    logic [LIM_W-1:0] lim_sh;
    tmr_state_e       state_q, state_d;
    logic             run_en, clear_en;
    logic             src_tick, div_tick;

    pwm_timebase_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg_q),
        .div_sh  (div_sh),
        .lim_sh  (lim_sh)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (!cfg_q[BIT_CLR])
                    state_d = cfg_q[BIT_HALT] ? ST_PAUSE : ST_RUN;
            end
            ST_RUN: begin
                if (cfg_q[BIT_CLR])       state_d = ST_HOLD;
                else if (cfg_q[BIT_HALT]) state_d = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (cfg_q[BIT_CLR])        state_d = ST_HOLD;
                else if (!cfg_q[BIT_HALT]) state_d = ST_RUN;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // State outputs
    always_comb begin
        run_en   = 1'b0;
        clear_en = 1'b0;
        unique case (state_q)
            ST_HOLD:  clear_en = 1'b1;
            ST_RUN:   run_en   = 1'b1;
            ST_PAUSE: ;
            default:  clear_en = 1'b1;
        endcase
    end

    assign src_tick = cfg_q[BIT_SEL] ? slow_tick : ref_tick;

    pwm_timebase_frac_div #(
        .DIV_W  (DIV_W),
        .FRAC_W (FRAC_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear_en),
        .advance (run_en && src_tick),
        .div_set (div_sh),
        .tick    (div_tick)
    );

    pwm_timebase_range_cnt #(
        .CNT_W (CNT_W),
        .LIM_W (LIM_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear_en),
        .step  (div_tick),
        .lim   (lim_sh),
        .cnt   (cnt),
        .wrap  (wrap)
    );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_q,
    input logic [DIV_W-1:0]  div_sh,
    input tmr_state_e        state_q,
    input logic              src_tick,
    input logic              div_tick,
    input logic [CNT_W-1:0]  cnt,
    input logic              wrap
);

    AST_TICK_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |-> src_tick); // R1

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + CNT_W'(1))); // R2

    AST_UPD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[BIT_UPD] && !cfg_we) |=> !cfg_q[BIT_UPD]); // R3

    AST_SHADOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[BIT_UPD] |=> $stable(div_sh)); // R3

    AST_HOLD_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (cnt == '0 && !wrap)); // R4

    AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE) |=> ($stable(cnt) && !wrap)); // R5

    AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (cnt == '0)); // R6

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_q    (cfg_q),
    .div_sh   (div_sh),
    .state_q  (state_q),
    .src_tick (src_tick),
    .div_tick (div_tick),
    .cnt      (cnt),
    .wrap     (wrap)
);

// File: tb/pwm_timebase_test.sv
`timescale 1ns/1ps
module pwm_timebase_test;

    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slow_tick = 1'b0;
    logic          ref_tick = 1'b0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [CW-1:0] cnt;
    logic          wrap;

    always #2 clk = ~clk;   // 250 MHz

    pwm_timebase #(.CNT_W(CW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .ref_tick  (ref_tick),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cnt       (cnt),
        .wrap      (wrap)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R8";

    // Scoreboard queues
    int    q_cnt [$];
    bit    q_wrap[$];
    string q_req [$];

    // Reference model state, from the requirements
    logic [31:0] m_cfg = '0;
    int m_mode = 0;   // 0 hold, 1 run, 2 pause
    int m_div = 0, m_lim = 0, m_acc = 0, m_cnt = 0;
    bit m_wrap = 1'b0;

    function automatic logic [31:0] mk(bit upd, bit sel, bit clr, bit halt, int dv, int lm);
        logic [31:0] w;
        w = '0;
        w[26] = upd; w[25] = sel; w[24] = clr; w[23] = halt;
        w[22:5] = dv[17:0];
        w[4:0] = lm[4:0];
        return w;
    endfunction

    task automatic model_step(bit we, logic [31:0] wd, bit s, bit r);
        logic [31:0] old;
        bit src;
        int a, deff, e, top;
        old = m_cfg;
        src = old[25] ? s : r;
        m_wrap = 1'b0;
        if (m_mode == 0) begin
            m_cnt = 0; m_acc = 0;
        end else if (m_mode == 1 && src) begin
            a = m_acc + 256;
            deff = (m_div < 256) ? 256 : m_div;
            if (a >= deff) begin
                m_acc = a - deff;
                e = (m_lim > CW) ? CW : m_lim;
                top = (1 << e) - 1;
                if (m_cnt == top) begin m_cnt = 0; m_wrap = 1'b1; end
                else m_cnt = m_cnt + 1;
            end else begin
                m_acc = a;
            end
        end
        if (old[26]) begin
            m_div = int'(old[22:5]);
            m_lim = int'(old[4:0]);
        end
        m_mode = old[24] ? 0 : (old[23] ? 2 : 1);
        if (we) m_cfg = wd;
        else    m_cfg = old & ~(32'd1 << 26);
        q_cnt.push_back(m_cnt);
        q_wrap.push_back(m_wrap);
        q_req.push_back(cur_req);
    endtask

    // Driver: one cycle of stimulus plus its expected result
    task automatic cyc(bit s, bit r, bit we = 1'b0, logic [31:0] wd = '0);
        @(negedge clk);
        #1;
        rst_n     = 1'b1;
        slow_tick = s;
        ref_tick  = r;
        cfg_we    = we;
        cfg_wdata = wd;
        model_step(we, wd, s, r);
    endtask

    // Monitor: compare each result one clock after its push
    always @(negedge clk) begin
        if (q_cnt.size() > 0) begin
            int ec;
            bit ew;
            string rq;
            ec = q_cnt.pop_front();
            ew = q_wrap.pop_front();
            rq = q_req.pop_front();
            n_cmp++;
            if (int'(cnt) != ec || wrap != ew) begin
                n_bad++;
                $display("FAIL %s: cnt=%0d wrap=%0d expected cnt=%0d wrap=%0d",
                         rq, cnt, wrap, ec, ew);
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R8: reset state, checked directly while reset is held
        repeat (2) @(negedge clk);
        n_cmp++;
        if (cnt != '0 || wrap != 1'b0) begin
            n_bad++;
            $display("FAIL R8: cnt=%0d wrap=%0d expected cnt=0 wrap=0", cnt, wrap);
        end
        cur_req = "R8";
        repeat (3) cyc(0, 0);

        // R9 / R2 / R6: ratio 1.0, exponent 2, reference tick every cycle
        cur_req = "R9";
        cyc(0, 0, 1, mk(1, 0, 0, 0, 256, 2));
        cur_req = "R2/R6";
        repeat (14) cyc(0, 1);

        // R1: ratio 2.5, exponent 3, ticks every cycle then every other
        cur_req = "R1";
        cyc(0, 1, 1, mk(1, 0, 0, 0, 640, 3));
        repeat (40) cyc(0, 1);
        for (int i = 0; i < 40; i++) cyc(0, i % 2);
        // R1: setting below 256 acts as 256
        cyc(0, 1, 1, mk(1, 0, 0, 0, 100, 2));
        repeat (20) cyc(0, 1);

        // R3: new fields without the update bit change nothing
        cur_req = "R3";
        cyc(0, 1, 1, mk(0, 0, 0, 0, 1024, 1));
        repeat (20) cyc(0, 1);
        cyc(0, 1, 1, mk(1, 0, 0, 0, 1024, 1));
        repeat (20) cyc(0, 1);
        // R3: a write landing as the update clears
        cyc(0, 1, 1, mk(1, 0, 0, 0, 384, 3));
        cyc(0, 1, 1, mk(0, 0, 0, 0, 384, 3));
        repeat (20) cyc(0, 1);

        // R7: select slow tick, reference noise ignored
        cur_req = "R7";
        cyc(0, 1, 1, mk(1, 1, 0, 0, 256, 3));
        for (int i = 0; i < 30; i++) cyc(i % 3 == 0, 1);
        cyc(1, 0, 1, mk(0, 0, 0, 0, 256, 3));
        for (int i = 0; i < 30; i++) cyc(1, i % 4 == 0);

        // R5: freeze mid-fraction, ticks keep coming
        cur_req = "R5";
        cyc(0, 1, 1, mk(1, 0, 0, 0, 600, 4));
        repeat (7) cyc(0, 1);
        cyc(0, 1, 1, mk(0, 0, 0, 1, 600, 4));
        repeat (20) cyc(0, 1);
        cyc(0, 1, 1, mk(0, 0, 0, 0, 600, 4));
        repeat (20) cyc(0, 1);

        // R4: clear holds counter and phase at 0
        cur_req = "R4";
        cyc(0, 1, 1, mk(0, 0, 1, 0, 600, 4));
        repeat (10) cyc(0, 1);
        cyc(0, 1, 1, mk(0, 0, 1, 1, 600, 4));
        repeat (4) cyc(0, 1);
        cyc(0, 1, 1, mk(0, 0, 0, 0, 600, 4));
        repeat (20) cyc(0, 1);

        // R2: exponent above the counter width is capped
        cur_req = "R2";
        cyc(0, 1, 1, mk(1, 0, 1, 0, 256, 25));
        repeat (3) cyc(0, 1);
        cyc(0, 1, 1, mk(0, 0, 0, 0, 256, 25));
        repeat (1100) cyc(0, 1);

        cyc(0, 0);
        @(negedge clk);
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule